// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides which NaN a two-input floating-point operation hands back when at least one of its operands is a NaN. It handles single-precision or double-precision words, picked by a static format input. Each operand is classified as a quiet NaN, a signalling NaN or an ordinary value. The invalid flag is raised when a signalling NaN is present. One of several static selection policies then picks an operand, and that operand is forced quiet before it leaves the block.

One policy prefers signalling NaNs in operand order. One takes the first operand whenever it is any NaN. The third compares significand magnitude, and breaks ties on sign, to choose between two NaNs of the same kind. A default-NaN mode replaces the chosen value with a fixed canonical pattern. The flag is still reported in that mode. The block captures one operand pair per cycle when `in_valid` is high and presents its result one clock later. Arithmetic on ordinary operands belongs to the surrounding datapath.

Top module: `nanprop_select`

## Requirements
- R1: A word is a NaN when its exponent field is all ones and its fraction is non-zero. It is quiet when the top fraction bit is 1 (bit 51 for double, bit 22 for single) and signalling when that bit is 0. `invalid` is 1 exactly when at least one operand is signalling, whether or not default-NaN mode is on.
- R2: With `dnan_mode` high and at least one NaN operand, `result` is the default NaN. For double that is 0x7FF8000000000000. For single it is 0x7FC00000 zero-extended to 64 bits.
- R3: With `policy` = 0, the result is taken from the first match in this list: A if signalling, B if signalling, A if quiet, and otherwise B.
- R4: With `policy` = 1, and likewise with the reserved value 3, the result comes from A if A is any NaN and from B otherwise.
- R5: With `policy` = 2, a signalling NaN paired with a quiet NaN yields the quiet one. A lone NaN paired with an ordinary value yields that NaN. Two NaNs of the same kind go to the magnitude rule of R6.
- R6: Of two same-kind NaNs, A wins when its word without the sign bit is greater than B's. When those are equal, A wins when its full word is numerically smaller, so the positive operand wins.
- R7: The chosen operand is output with its quiet bit forced to 1 and every other bit unchanged. A signalling NaN never appears on `result`.
- R8: When neither operand is a NaN, `nan_valid` is 0 and `invalid` is 0.
- R9: In single format (`fmt_dbl` = 0), only bits 31:0 of each operand are examined, and bits 63:32 of `result` are 0.
- R10: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision (static) |
| policy | input | 2 | Selection policy: 0 ordered, 1 first NaN, 2 magnitude, 3 as 1 (static) |
| dnan_mode | input | 1 | Replace the result with the default NaN |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| out_valid | output | 1 | Result registers hold a new result |
| nan_valid | output | 1 | At least one operand was a NaN |
| invalid | output | 1 | At least one operand was a signalling NaN |
| result | output | 64 | Selected, quieted NaN or default NaN |

## Verification
The bench runs every ordered pair drawn from a set of quiet, signalling and ordinary words under all four policy codes, both formats and both mode settings. The set includes pairs that differ only in sign and pairs of the same kind whose magnitudes differ. A design with an inverted tie-break returns the negative NaN where the positive one belongs. A design that skips quieting lets a signalling pattern through. A design that lets default-NaN mode mask the flag drops `invalid`. The single-format vectors carry non-zero upper halves. A design that reads or passes those bits misclassifies operands or leaks garbage into `result[63:32]`.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

   typedef enum logic [1:0] {
      POL_ORDERED   = 2'd0,
      POL_FIRST_NAN = 2'd1,
      POL_MAGNITUDE = 2'd2,
      POL_RESERVED  = 2'd3
   } nan_policy_e;

   typedef struct packed {
      logic is_nan;
      logic is_sig;
      logic is_qui;
   } nan_class_t;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
   import nanprop_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int FRC_W = 23
) (
   input  logic [EXP_W+FRC_W-1:0] mag,
   output nan_class_t             cls
);

   logic exp_ones;
   logic frac_nz;

   assign exp_ones   = &mag[FRC_W +: EXP_W];
   assign frac_nz    = |mag[FRC_W-1:0];
   assign cls.is_nan = exp_ones & frac_nz;
   assign cls.is_qui = exp_ones & frac_nz & mag[FRC_W-1];
   assign cls.is_sig = exp_ones & frac_nz & ~mag[FRC_W-1];

endmodule

// File: rtl/nanprop_magcmp.sv
module nanprop_magcmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] word_a,
   input  logic [W-1:0] word_b,
   output logic         a_larger
);

   logic mag_gt;
   logic mag_eq;
   logic raw_lt;

   assign mag_gt   = word_a[W-2:0] >  word_b[W-2:0];
   assign mag_eq   = word_a[W-2:0] == word_b[W-2:0];
   assign raw_lt   = word_a < word_b;
   assign a_larger = mag_gt | (mag_eq & raw_lt);

endmodule

// File: rtl/nanprop_policy.sv
module nanprop_policy
   import nanprop_pkg::*;
(
   input  nan_policy_e pol,
   input  nan_class_t  cls_a,
   input  nan_class_t  cls_b,
   input  logic        a_larger,
   output logic        pick_b
);

   always_comb begin
      pick_b = 1'b1;
      unique case (pol)
         POL_ORDERED: begin
            if (cls_a.is_sig)      pick_b = 1'b0;
            else if (cls_b.is_sig) pick_b = 1'b1;
            else if (cls_a.is_qui) pick_b = 1'b0;
            else                   pick_b = 1'b1;
         end
         POL_MAGNITUDE: begin
            if (cls_a.is_sig) begin
               if (cls_b.is_sig)      pick_b = ~a_larger;
               else if (cls_b.is_qui) pick_b = 1'b1;
               else                   pick_b = 1'b0;
            end else if (cls_a.is_qui) begin
               if (cls_b.is_qui)      pick_b = ~a_larger;
               else                   pick_b = 1'b0;
            end else begin
               pick_b = 1'b1;
            end
         end
         POL_FIRST_NAN, POL_RESERVED: begin
            pick_b = ~cls_a.is_nan;
         end
         default: pick_b = 1'b1;
      endcase
   end

endmodule

// File: rtl/nanprop_select.sv
module nanprop_select
   import nanprop_pkg::*;
#(
   parameter int EXP_S = 8,
   parameter int FRC_S = 23,
   parameter int EXP_D = 11,
   parameter int FRC_D = 52
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     fmt_dbl,
   input  logic [1:0]               policy,
   input  logic                     dnan_mode,
   input  logic [EXP_D+FRC_D:0]     op_a,
   input  logic [EXP_D+FRC_D:0]     op_b,
   output logic                     out_valid,
   output logic                     nan_valid,
   output logic                     invalid,
   output logic [EXP_D+FRC_D:0]     result
);

   localparam int W_S = 1 + EXP_S + FRC_S;
   localparam int W_D = 1 + EXP_D + FRC_D;

   if (W_D < W_S) begin : g_bad_width
      $error("double format must be at least as wide as single format");
   end
   if (FRC_S < 2 || EXP_S < 2) begin : g_bad_single
      $error("single format fields too narrow");
   end

   nan_class_t       cls_a_f   [2];
   nan_class_t       cls_b_f   [2];
   logic             larger_f  [2];
   logic [W_D-1:0]   qa_f      [2];
   logic [W_D-1:0]   qb_f      [2];
   logic [W_D-1:0]   dflt_f    [2];

   for (genvar g = 0; g < 2; g++) begin : g_fmt
      localparam int EW  = (g == 0) ? EXP_S : EXP_D;
      localparam int FRW = (g == 0) ? FRC_S : FRC_D;
      localparam int FW  = 1 + EW + FRW;
      localparam logic [FW-1:0] QMASK = FW'(1) << (FRW - 1);
      localparam logic [FW-1:0] DFLT  = {1'b0, {EW{1'b1}}, 1'b1, {(FRW-1){1'b0}}};

      logic [FW-1:0] wa;
      logic [FW-1:0] wb;

      assign wa = op_a[FW-1:0];
      assign wb = op_b[FW-1:0];

      nanprop_classify #(.EXP_W(EW), .FRC_W(FRW)) i_cls_a (
         .mag (wa[FW-2:0]),
         .cls (cls_a_f[g])
      );

      nanprop_classify #(.EXP_W(EW), .FRC_W(FRW)) i_cls_b (
         .mag (wb[FW-2:0]),
         .cls (cls_b_f[g])
      );

      nanprop_magcmp #(.W(FW)) i_cmp (
         .word_a   (wa),
         .word_b   (wb),
         .a_larger (larger_f[g])
      );

      assign qa_f[g]   = W_D'(wa | QMASK);
      assign qb_f[g]   = W_D'(wb | QMASK);
      assign dflt_f[g] = W_D'(DFLT);
   end

   nan_class_t     cls_a;
   nan_class_t     cls_b;
   logic           a_larger;
   logic           pick_b;
   logic [W_D-1:0] sel_word;
   logic           any_nan;
   logic           any_sig;

   assign cls_a    = fmt_dbl ? cls_a_f[1]  : cls_a_f[0];
   assign cls_b    = fmt_dbl ? cls_b_f[1]  : cls_b_f[0];
   assign a_larger = fmt_dbl ? larger_f[1] : larger_f[0];

   nanprop_policy i_pol (
      .pol      (nan_policy_e'(policy)),
      .cls_a    (cls_a),
      .cls_b    (cls_b),
      .a_larger (a_larger),
      .pick_b   (pick_b)
   );

   assign any_nan = cls_a.is_nan | cls_b.is_nan;
   assign any_sig = cls_a.is_sig | cls_b.is_sig;

   always_comb begin
      if (dnan_mode)   sel_word = fmt_dbl ? dflt_f[1] : dflt_f[0];
      else if (pick_b) sel_word = fmt_dbl ? qb_f[1]   : qb_f[0];
      else             sel_word = fmt_dbl ? qa_f[1]   : qa_f[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         nan_valid <= 1'b0;
         invalid   <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            nan_valid <= any_nan;
            invalid   <= any_sig;
            result    <= sel_word;
         end
      end
   end

endmodule

// File: rtl/nanprop_checker.sv
module nanprop_checker #(
   parameter int EXP_S = 8,
   parameter int FRC_S = 23,
   parameter int EXP_D = 11,
   parameter int FRC_D = 52
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 fmt_dbl,
   input logic                 dnan_mode,
   input logic                 out_valid,
   input logic                 nan_valid,
   input logic                 invalid,
   input logic [EXP_D+FRC_D:0] result
);

   localparam int W_S = 1 + EXP_S + FRC_S;
   localparam int W_D = 1 + EXP_D + FRC_D;
   localparam logic [W_D-1:0] DN_D = {1'b0, {EXP_D{1'b1}}, 1'b1, {(FRC_D-1){1'b0}}};
   localparam logic [W_D-1:0] DN_S = W_D'({1'b0, {EXP_S{1'b1}}, 1'b1, {(FRC_S-1){1'b0}}});

   AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10

   AST_NO_NAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !nan_valid) |-> !invalid); // R8

   AST_QUIET_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && nan_valid && $past(fmt_dbl)) |-> result[FRC_D-1]); // R7

   AST_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && nan_valid && !$past(fmt_dbl)) |-> result[FRC_S-1]); // R7

   AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && nan_valid && !$past(fmt_dbl)) |-> (result[W_D-1:W_S] == '0)); // R9

   AST_DEFAULT_NAN_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && nan_valid && $past(dnan_mode) && $past(fmt_dbl)) |-> (result == DN_D)); // R2

   AST_DEFAULT_NAN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && nan_valid && $past(dnan_mode) && !$past(fmt_dbl)) |-> (result == DN_S)); // R2

endmodule

bind nanprop_select nanprop_checker #(
   .EXP_S (EXP_S),
   .FRC_S (FRC_S),
   .EXP_D (EXP_D),
   .FRC_D (FRC_D)
) i_nanprop_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .fmt_dbl   (fmt_dbl),
   .dnan_mode (dnan_mode),
   .out_valid (out_valid),
   .nan_valid (nan_valid),
   .invalid   (invalid),
   .result    (result)
);

// File: tb/test_nanprop_select.sv
module test_nanprop_select;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        fmt_dbl = 1'b0;
   logic [1:0]  policy = 2'd0;
   logic        dnan_mode = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        out_valid;
   logic        nan_valid;
   logic        invalid;
   logic [63:0] result;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // expected item: {dbl, nan_valid, invalid, result}
   logic [66:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   nanprop_select i_nanprop_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .fmt_dbl   (fmt_dbl),
      .policy    (policy),
      .dnan_mode (dnan_mode),
      .op_a      (op_a),
      .op_b      (op_b),
      .out_valid (out_valid),
      .nan_valid (nan_valid),
      .invalid   (invalid),
      .result    (result)
   );

   function automatic logic [65:0] ref_model(input logic dbl, input logic [1:0] pol,
                                             input logic dn, input logic [63:0] a,
                                             input logic [63:0] b);
      logic [63:0] aw, bw, qmask, dflt, pick;
      logic [62:0] ma, mb;
      logic an, aq, as_, bn, bq, bs, larger, choose_b;
      if (dbl) begin
         aw = a; bw = b;
         an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
         bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
         aq = an && a[51]; bq = bn && b[51];
         ma = a[62:0]; mb = b[62:0];
         qmask = 64'h0008_0000_0000_0000;
         dflt  = 64'h7FF8_0000_0000_0000;
      end else begin
         aw = {32'h0, a[31:0]}; bw = {32'h0, b[31:0]};
         an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
         bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
         aq = an && a[22]; bq = bn && b[22];
         ma = {32'h0, a[30:0]}; mb = {32'h0, b[30:0]};
         qmask = 64'h0000_0000_0040_0000;
         dflt  = 64'h0000_0000_7FC0_0000;
      end
      as_ = an && !aq;
      bs  = bn && !bq;
      larger = (ma > mb) || ((ma == mb) && (aw < bw));
      case (pol)
         2'd0: choose_b = as_ ? 1'b0 : (bs ? 1'b1 : (aq ? 1'b0 : 1'b1));
         2'd2: begin
            if (as_)     choose_b = bs ? !larger : bq;
            else if (aq) choose_b = bq ? !larger : 1'b0;
            else         choose_b = 1'b1;
         end
         default: choose_b = !an;
      endcase
      pick = choose_b ? bw : aw;
      if (dn) pick = dflt;
      else    pick = pick | qmask;
      return {an || bn, as_ || bs, pick};
   endfunction

   function automatic logic [63:0] pattern(input logic dbl, input int k);
      logic [63:0] p;
      if (dbl) begin
         case (k)
            0: p = 64'h7FF8_0000_0000_0001; // quiet, small
            1: p = 64'h7FFC_0000_0000_0000; // quiet, larger
            2: p = 64'h7FF0_0000_0000_0001; // signalling, small
            3: p = 64'hFFF4_0000_0000_0000; // signalling, negative
            4: p = 64'h3FF0_0000_0000_0000; // ordinary 1.0
            5: p = 64'hFFF8_0000_0000_0001; // quiet, same magnitude as 0, negative
            default: p = 64'h7FF4_0000_0000_0000; // signalling, same magnitude as 3, positive
         endcase
      end else begin
         case (k)
            0: p = 64'hDEAD_BEEF_7FC0_0001;
            1: p = 64'h1234_5678_7FE0_0000;
            2: p = 64'hFFFF_FFFF_7F80_0001;
            3: p = 64'h0BAD_F00D_FFA0_0000;
            4: p = 64'h7FF8_0000_3F80_0000; // upper half is a NaN pattern, must be ignored (R9)
            5: p = 64'hA5A5_A5A5_FFC0_0001;
            default: p = 64'h5A5A_5A5A_7FA0_0000;
         endcase
      end
      return p;
   endfunction

   task automatic drive(input logic dbl, input logic [1:0] pol, input logic dn,
                        input logic [63:0] a, input logic [63:0] b);
      logic [65:0] e;
      logic a_s, b_s, a_q, b_q;
      string t;
      @(negedge clk);
      fmt_dbl = dbl; policy = pol; dnan_mode = dn; op_a = a; op_b = b;
      in_valid = 1'b1;
      e = ref_model(dbl, pol, dn, a, b);
      a_s = dbl ? (a[62:52] == 11'h7FF && a[51:0] != 0 && !a[51])
                : (a[30:23] == 8'hFF && a[22:0] != 0 && !a[22]);
      b_s = dbl ? (b[62:52] == 11'h7FF && b[51:0] != 0 && !b[51])
                : (b[30:23] == 8'hFF && b[22:0] != 0 && !b[22]);
      a_q = dbl ? (a[62:52] == 11'h7FF && a[51]) : (a[30:23] == 8'hFF && a[22]);
      b_q = dbl ? (b[62:52] == 11'h7FF && b[51]) : (b[30:23] == 8'hFF && b[22]);
      if (!e[65])                                 t = "R8";
      else if (dn)                                t = "R2";
      else if (pol == 2'd2 && ((a_s && b_s) || (a_q && b_q))) t = "R6";
      else if (pol == 2'd0)                       t = "R3";
      else if (pol == 2'd2)                       t = "R5";
      else                                        t = "R4";
      exp_q.push_back({dbl, e});
      tag_q.push_back(t);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R10 out_valid without pending input: actual 1 expected 0");
         end else begin
            logic [66:0] it;
            string t;
            it = exp_q.pop_front();
            t  = tag_q.pop_front();
            n_chk++;
            if (nan_valid !== it[65]) begin
               n_fail++;
               $display("FAIL R8 nan_valid: actual %0b expected %0b", nan_valid, it[65]);
            end
            n_chk++;
            if (invalid !== it[64]) begin
               n_fail++;
               $display("FAIL R1 invalid: actual %0b expected %0b", invalid, it[64]);
            end
            if (it[65]) begin
               n_chk++;
               if (result !== it[63:0]) begin
                  n_fail++;
                  $display("FAIL %s result: actual %h expected %h", t, result, it[63:0]);
               end
               n_chk++; // R7: quiet bit of the format is set
               if ((it[66] ? result[51] : result[22]) !== 1'b1) begin
                  n_fail++;
                  $display("FAIL R7 quiet bit: actual 0 expected 1 (result %h)", result);
               end
               if (!it[66]) begin
                  n_chk++; // R9: upper half zero in single format
                  if (result[63:32] !== 32'h0) begin
                     n_fail++;
                     $display("FAIL R9 upper half: actual %h expected 00000000", result[63:32]);
                  end
               end
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++; // R10: reset state
      if (out_valid !== 1'b0 || nan_valid !== 1'b0 || invalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset state: actual %0b%0b%0b expected 000",
                  out_valid, nan_valid, invalid);
      end
      rst_n = 1'b1;
      for (int f = 0; f < 2; f++) begin
         for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 2; d++) begin
               for (int i = 0; i < 7; i++) begin
                  for (int j = 0; j < 7; j++) begin
                     drive(f[0], p[1:0], d[0], pattern(f[0], i), pattern(f[0], j));
                  end
               end
               @(negedge clk);
               in_valid = 1'b0;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      n_chk++; // R10: idle after the last input
      if (out_valid !== 1'b0 || exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R10 idle: actual out_valid %0b pending %0d expected 0 0",
                  out_valid, exp_q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1_500_000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R10 watchdog expired: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule